// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block sits between a bus unit and an execution unit. It keeps a small first-in first-out store of instruction bytes. When the execution side leaves the bus idle, the block requests opcode fetches from memory and pushes the returned bytes into the store. The execution side takes bytes from the head one at a time. It marks each pop as either the opening byte of an instruction or a later byte of one. When a jump or call changes the flow of the program, the execution side raises a redirect with a new address. Every queued byte is then thrown away, and fetching starts again at that address.

Fetches use a single request/acknowledge handshake. The request carries a byte address and a width flag. The response is a 16-bit word, with the even-address byte in bits 7:0 and the odd-address byte in bits 15:8. A controller with three states drives the fetch side:

- `FS_IDLE`: no request is outstanding.
- `FS_REQ`: a request is outstanding and its bytes will be kept.
- `FS_DRAIN`: a request is outstanding but a redirect has made it stale.

The transitions are as follows:

- *issue* (`FS_IDLE` to `FS_REQ`): the bus is free, no redirect is present and there is enough room.
- *complete* (`FS_REQ` to `FS_IDLE`): an acknowledge arrives.
- *orphan* (`FS_REQ` to `FS_DRAIN`): a redirect arrives without an acknowledge.
- *retire* (`FS_DRAIN` to `FS_IDLE`): an acknowledge arrives, and its data is discarded.

In every other case the controller holds its state. Each cycle the block also reports what happened to the queue as a 2-bit status code.

Top module: `prefetch_queue`

## Requirements
- R1: The queue holds at most DEPTH (default 6) bytes. Bytes leave in exactly the order of their addresses, starting at the last redirect target (or at RESET_ADDR after reset).
- R2: A fetch request is raised only in the cycle after one in which `bus_busy_i` and `redirect_i` were both low and no request was outstanding.
- R3: A redirect empties the queue by the following cycle. The next bytes delivered come from the redirect address.
- R4: `qstat_o` is 2'b10 in a redirect cycle. Otherwise it is 2'b01 for an accepted pop with `pop_first_i` high, 2'b11 for an accepted pop with `pop_first_i` low, and 2'b00 when no pop is accepted.
- R5: At an even fetch address, the block issues a word fetch (`fetch_byte_o` low). It pushes bits 7:0 of the response and then bits 15:8, and the fetch address advances by 2.
- R6: A word fetch is issued only when at least 2 entries are free. A byte fetch is issued only when at least 1 is free. With no pops, the queue therefore settles at 6 bytes from an even start and at 5 bytes from an odd start.
- R7: At an odd fetch address, the block issues a single-byte fetch (`fetch_byte_o` high). It pushes only bits 15:8 of the response, and the fetch address advances by 1.
- R8: A response to a request that was outstanding when a redirect arrived is discarded. The next request goes to the redirect address only after that response.
- R9: A pop while the queue is empty (`pop_empty_o` high) is not accepted. It leaves the head byte unchanged and yields status 2'b00.
- R10: Once raised, `fetch_req_o` stays high with a stable `fetch_addr_o` and `fetch_byte_o` until the cycle in which `fetch_ack_i` is high.
- R11: During and after reset the queue is empty, the status is 2'b00 and no request is raised. The first fetch goes to RESET_ADDR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_busy_i | input | 1 | Execution side holds the bus this cycle |
| redirect_i | input | 1 | Jump or call: discard the queue and refetch |
| redirect_addr_i | input | ADDR_W | New fetch address for a redirect |
| pop_i | input | 1 | Execution side takes the head byte |
| pop_first_i | input | 1 | The popped byte opens an instruction |
| pop_byte_o | output | 8 | Head byte of the queue |
| pop_empty_o | output | 1 | Queue holds no byte |
| fetch_req_o | output | 1 | Fetch request, held until acknowledged |
| fetch_addr_o | output | ADDR_W | Byte address of the fetch |
| fetch_byte_o | output | 1 | High for a single-byte fetch at an odd address |
| fetch_ack_i | input | 1 | Fetch response valid this cycle |
| fetch_data_i | input | 16 | Fetched word, even byte in bits 7:0 |
| qstat_o | output | 2 | Queue status code for this cycle |

## Verification
The bench goes after five corner cases:

- **Redirect against an outstanding request.** A design that kept the stale response would insert foreign bytes at the head of the new stream, and the scoreboard would see them out of order.
- **Fill limit from even and odd starts.** A design with a wrong room check would either overflow and lose bytes, or stop one byte short. The number of bytes drained would then differ from 6 or 5.
- **Odd redirect target.** A design that still issued a word fetch would deliver the even byte below the target first.
- **Pop while empty.** A design that accepted it would advance the head past a byte never fetched, or report a pop code.
- **Request with a slow acknowledge.** A design that changed its address before the acknowledge would return bytes from the wrong location.

// File: rtl/pq_pkg.sv
package pq_pkg;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_REQ   = 2'd1,
        FS_DRAIN = 2'd2
    } fetch_state_t;

    typedef enum logic [1:0] {
        QS_NONE  = 2'b00,
        QS_FIRST = 2'b01,
        QS_FLUSH = 2'b10,
        QS_NEXT  = 2'b11
    } qstat_t;

endpackage

// File: rtl/pq_byte_fifo.sv
module pq_byte_fifo #(
    parameter int DEPTH = 6,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [1:0]       push_n,
    input  logic [7:0]       push_b0,
    input  logic [7:0]       push_b1,
    input  logic             pop,
    output logic [7:0]       head,
    output logic             empty,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] free
);
    localparam int SUM_W = PTR_W + 2;

    logic [DEPTH-1:0][7:0] slots;
    logic [PTR_W-1:0]      rd_ptr;
    logic [PTR_W-1:0]      wr0;
    logic [PTR_W-1:0]      wr1;

    function automatic logic [PTR_W-1:0] wrap(input logic [SUM_W-1:0] x);
        if (x >= SUM_W'(DEPTH)) begin
            return PTR_W'(x - SUM_W'(DEPTH));
        end
        return PTR_W'(x);
    endfunction

    always_comb begin
        wr0 = wrap(SUM_W'(rd_ptr) + SUM_W'(count));
        wr1 = wrap(SUM_W'(wr0) + SUM_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slots <= '0;
        end else if (!clr) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (push_n != 2'd0 && wr0 == PTR_W'(i)) begin
                    slots[i] <= push_b0;
                end else if (push_n == 2'd2 && wr1 == PTR_W'(i)) begin
                    slots[i] <= push_b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (pop) begin
                rd_ptr <= wrap(SUM_W'(rd_ptr) + SUM_W'(1));
            end
            count <= count + CNT_W'(push_n) - CNT_W'(pop);
        end
    end

    always_comb begin
        head  = slots[rd_ptr];
        empty = (count == '0);
        free  = CNT_W'(DEPTH) - count;
    end

endmodule

// File: rtl/pq_fetch_ctrl.sv
module pq_fetch_ctrl
    import pq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CNT_W = 3,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_busy,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] redirect_addr,
    input  logic [CNT_W-1:0]  free,
    input  logic              ack,
    input  logic [15:0]       data,
    output logic              req,
    output logic [ADDR_W-1:0] req_addr,
    output logic              req_byte,
    output logic [1:0]        push_n,
    output logic [7:0]        push_b0,
    output logic [7:0]        push_b1
);
    fetch_state_t      state;
    fetch_state_t      state_nxt;
    logic [ADDR_W-1:0] next_ptr;
    logic              issue;
    logic              accept;
    logic              room;

    always_comb begin
        room   = next_ptr[0] ? (free >= CNT_W'(1)) : (free >= CNT_W'(2));
        issue  = (state == FS_IDLE) && !redirect && !bus_busy && room;
        accept = (state == FS_REQ) && ack && !redirect;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            FS_IDLE:  if (issue) state_nxt = FS_REQ;
            FS_REQ:   if (ack) state_nxt = FS_IDLE;
                      else if (redirect) state_nxt = FS_DRAIN;
            FS_DRAIN: if (ack) state_nxt = FS_IDLE;
            default:  state_nxt = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= FS_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            next_ptr <= RESET_ADDR;
            req_addr <= '0;
            req_byte <= 1'b0;
        end else begin
            if (redirect) begin
                next_ptr <= redirect_addr;
            end else if (accept) begin
                next_ptr <= next_ptr + (req_byte ? ADDR_W'(1) : ADDR_W'(2));
            end
            if (issue) begin
                req_addr <= next_ptr;
                req_byte <= next_ptr[0];
            end
        end
    end

    always_comb begin
        req     = (state != FS_IDLE);
        push_n  = accept ? (req_byte ? 2'd1 : 2'd2) : 2'd0;
        push_b0 = req_byte ? data[15:8] : data[7:0];
        push_b1 = data[15:8];
    end

endmodule

// File: rtl/pq_status_enc.sv
module pq_status_enc
    import pq_pkg::*;
(
    input  logic   redirect,
    input  logic   pop_ok,
    input  logic   first,
    output qstat_t code
);
    always_comb begin
        if (redirect) begin
            code = QS_FLUSH;
        end else if (pop_ok) begin
            code = first ? QS_FIRST : QS_NEXT;
        end else begin
            code = QS_NONE;
        end
    end
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
    import pq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DEPTH = 6,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_busy_i,
    input  logic              redirect_i,
    input  logic [ADDR_W-1:0] redirect_addr_i,
    input  logic              pop_i,
    input  logic              pop_first_i,
    output logic [7:0]        pop_byte_o,
    output logic              pop_empty_o,
    output logic              fetch_req_o,
    output logic [ADDR_W-1:0] fetch_addr_o,
    output logic              fetch_byte_o,
    input  logic              fetch_ack_i,
    input  logic [15:0]       fetch_data_i,
    output logic [1:0]        qstat_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [1:0]       push_n;
    logic [7:0]       push_b0;
    logic [7:0]       push_b1;
    logic [CNT_W-1:0] fill_count;
    logic [CNT_W-1:0] fill_free;
    logic             empty;
    logic             pop_ok;
    qstat_t           code;

    assign pop_ok = pop_i && !empty && !redirect_i;

    pq_byte_fifo #(.DEPTH(DEPTH)) fifo_i (
        .clk     (clk),
        .rst     (rst),
        .clr     (redirect_i),
        .push_n  (push_n),
        .push_b0 (push_b0),
        .push_b1 (push_b1),
        .pop     (pop_ok),
        .head    (pop_byte_o),
        .empty   (empty),
        .count   (fill_count),
        .free    (fill_free)
    );

    pq_fetch_ctrl #(
        .ADDR_W     (ADDR_W),
        .CNT_W      (CNT_W),
        .RESET_ADDR (RESET_ADDR)
    ) fetch_i (
        .clk           (clk),
        .rst           (rst),
        .bus_busy      (bus_busy_i),
        .redirect      (redirect_i),
        .redirect_addr (redirect_addr_i),
        .free          (fill_free),
        .ack           (fetch_ack_i),
        .data          (fetch_data_i),
        .req           (fetch_req_o),
        .req_addr      (fetch_addr_o),
        .req_byte      (fetch_byte_o),
        .push_n        (push_n),
        .push_b0       (push_b0),
        .push_b1       (push_b1)
    );

    pq_status_enc status_i (
        .redirect (redirect_i),
        .pop_ok   (pop_ok),
        .first    (pop_first_i),
        .code     (code)
    );

    assign pop_empty_o = empty;
    assign qstat_o     = code;

endmodule

// File: rtl/pq_checker.sv
module pq_checker #(
    parameter int ADDR_W = 20,
    parameter int DEPTH = 6,
    parameter int CNT_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_busy_i,
    input logic              redirect_i,
    input logic              pop_i,
    input logic              pop_empty_o,
    input logic              fetch_req_o,
    input logic [ADDR_W-1:0] fetch_addr_o,
    input logic              fetch_byte_o,
    input logic              fetch_ack_i,
    input logic [1:0]        qstat_o,
    input logic [CNT_W-1:0]  fill_count,
    input logic [CNT_W-1:0]  fill_free
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        fill_count <= CNT_W'(DEPTH)); // R1

    AST_REQ_ON_FREE_BUS: assert property (@(posedge clk) disable iff (rst)
        $rose(fetch_req_o) |-> $past(!bus_busy_i && !redirect_i)); // R2

    AST_REDIRECT_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        redirect_i |=> pop_empty_o); // R3

    AST_POP_CODE: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !pop_empty_o && !redirect_i) |-> qstat_o[0]); // R4

    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (fetch_req_o && !fetch_byte_o) |-> !fetch_addr_o[0]); // R5

    AST_ROOM_BEFORE_FETCH: assert property (@(posedge clk) disable iff (rst)
        $rose(fetch_req_o) |-> ($past(fill_free) >= (fetch_byte_o ? CNT_W'(1) : CNT_W'(2)))); // R6

    AST_ODD_IS_BYTE: assert property (@(posedge clk) disable iff (rst)
        (fetch_req_o && fetch_addr_o[0]) |-> fetch_byte_o); // R7

    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (rst)
        (pop_empty_o && !redirect_i) |-> (qstat_o == 2'b00)); // R9

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (fetch_req_o && !fetch_ack_i) |=> (fetch_req_o && $stable(fetch_addr_o) && $stable(fetch_byte_o))); // R10

endmodule

bind prefetch_queue pq_checker #(
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .bus_busy_i   (bus_busy_i),
    .redirect_i   (redirect_i),
    .pop_i        (pop_i),
    .pop_empty_o  (pop_empty_o),
    .fetch_req_o  (fetch_req_o),
    .fetch_addr_o (fetch_addr_o),
    .fetch_byte_o (fetch_byte_o),
    .fetch_ack_i  (fetch_ack_i),
    .qstat_o      (qstat_o),
    .fill_count   (fill_count),
    .fill_free    (fill_free)
);

// File: tb/prefetch_queue_tb_top.sv
module prefetch_queue_tb_top;
    localparam int ADDR_W = 20;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_busy_i = 1'b1;
    logic              redirect_i = 1'b0;
    logic [ADDR_W-1:0] redirect_addr_i = '0;
    logic              pop_i = 1'b0;
    logic              pop_first_i = 1'b0;
    logic [7:0]        pop_byte_o;
    logic              pop_empty_o;
    logic              fetch_req_o;
    logic [ADDR_W-1:0] fetch_addr_o;
    logic              fetch_byte_o;
    logic              fetch_ack_i = 1'b0;
    logic [15:0]       fetch_data_i = '0;
    logic [1:0]        qstat_o;

    int          checks = 0;
    int          fails = 0;
    int          lat = 1;
    logic [7:0]  sb_q[$];

    always #5 clk = ~clk;

    prefetch_queue #(.ADDR_W(ADDR_W), .DEPTH(6), .RESET_ADDR('0)) dut_i (
        .clk             (clk),
        .rst             (rst),
        .bus_busy_i      (bus_busy_i),
        .redirect_i      (redirect_i),
        .redirect_addr_i (redirect_addr_i),
        .pop_i           (pop_i),
        .pop_first_i     (pop_first_i),
        .pop_byte_o      (pop_byte_o),
        .pop_empty_o     (pop_empty_o),
        .fetch_req_o     (fetch_req_o),
        .fetch_addr_o    (fetch_addr_o),
        .fetch_byte_o    (fetch_byte_o),
        .fetch_ack_i     (fetch_ack_i),
        .fetch_data_i    (fetch_data_i),
        .qstat_o         (qstat_o)
    );

    function automatic logic [7:0] mb(input logic [ADDR_W-1:0] a);
        return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]} ^ 8'h3C;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // driver side of the scoreboard: expected byte stream from an address
    task automatic expect_stream(input logic [ADDR_W-1:0] a);
        sb_q.delete();
        for (int i = 0; i < 64; i++) sb_q.push_back(mb(a + ADDR_W'(i)));
    endtask

    task automatic redirect_to(input logic [ADDR_W-1:0] a);
        redirect_i = 1'b1;
        redirect_addr_i = a;
        expect_stream(a);
        @(negedge clk);
        chk(qstat_o == 2'b10, "R4", "status in redirect cycle", qstat_o, 2);
        tick();
        redirect_i = 1'b0;
        @(negedge clk);
        chk(pop_empty_o == 1'b1, "R3", "empty after redirect", pop_empty_o, 1);
        tick();
    endtask

    task automatic do_pops(input int n);
        int got = 0;
        while (got < n) begin
            pop_i = 1'b1;
            pop_first_i = (got % 3 == 0);
            @(negedge clk);
            if (!pop_empty_o) got++;
            tick();
        end
        pop_i = 1'b0;
        pop_first_i = 1'b0;
    endtask

    task automatic drain_count(output int got);
        got = 0;
        forever begin
            pop_i = 1'b1;
            pop_first_i = 1'b0;
            @(negedge clk);
            if (pop_empty_o) break;
            got++;
            tick();
        end
        pop_i = 1'b0;
        tick();
    endtask

    task automatic wait_req();
        for (int i = 0; i < 100 && !fetch_req_o; i++) tick();
    endtask

    // monitor side of the scoreboard
    always @(negedge clk) begin
        if (!rst && pop_i && !pop_empty_o && !redirect_i) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R1", "unexpected byte", pop_byte_o, 0);
            end else begin
                logic [7:0] e;
                e = sb_q.pop_front();
                chk(pop_byte_o == e, "R1", "byte order", pop_byte_o, e);
            end
            chk(qstat_o == (pop_first_i ? 2'b01 : 2'b11), "R4", "pop status",
                qstat_o, pop_first_i ? 1 : 3);
        end
    end

    // memory responder
    initial begin
        int cnt = 0;
        logic [ADDR_W-1:0] cap = '0;
        logic              capb = 1'b0;
        forever begin
            tick();
            if (rst || fetch_ack_i) begin
                fetch_ack_i = 1'b0;
                cnt = 0;
            end else if (fetch_req_o) begin
                if (cnt == 0) begin
                    cap = fetch_addr_o;
                    capb = fetch_byte_o;
                end else begin
                    chk(fetch_addr_o == cap && fetch_byte_o == capb, "R10",
                        "request held", fetch_addr_o, cap);
                end
                if (cnt >= lat) begin
                    fetch_ack_i = 1'b1;
                    fetch_data_i = {mb(cap | ADDR_W'(1)), mb(cap & ~ADDR_W'(1))};
                end else begin
                    cnt++;
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int n;
        expect_stream('0);
        repeat (3) tick();
        @(negedge clk);
        chk(pop_empty_o == 1'b1, "R11", "empty in reset", pop_empty_o, 1);
        chk(fetch_req_o == 1'b0, "R11", "no request in reset", fetch_req_o, 0);
        tick();
        rst = 1'b0;
        repeat (2) tick();
        @(negedge clk);
        chk(qstat_o == 2'b00, "R11", "status idle after reset", qstat_o, 0);
        chk(fetch_req_o == 1'b0, "R2", "no request while busy", fetch_req_o, 0);
        tick();

        // R11 / R5: first fetch at reset address, word wide
        bus_busy_i = 1'b0;
        wait_req();
        @(negedge clk);
        chk(fetch_addr_o == '0, "R11", "first fetch address", fetch_addr_o, 0);
        chk(fetch_byte_o == 1'b0, "R5", "word fetch at even", fetch_byte_o, 0);
        tick();
        do_pops(10);

        // R6: fill from an even start with no pops
        redirect_to(20'h01230);
        repeat (40) tick();
        @(negedge clk);
        chk(fetch_req_o == 1'b0, "R6", "no fetch when full", fetch_req_o, 0);
        tick();
        bus_busy_i = 1'b1;
        drain_count(n);
        chk(n == 6, "R6", "bytes held from even start", n, 6);

        // R7: odd start uses a byte fetch and settles at five
        bus_busy_i = 1'b0;
        redirect_to(20'h04561);
        wait_req();
        @(negedge clk);
        chk(fetch_byte_o == 1'b1, "R7", "byte fetch at odd", fetch_byte_o, 1);
        chk(fetch_addr_o == 20'h04561, "R7", "odd fetch address", fetch_addr_o, 20'h04561);
        tick();
        repeat (40) tick();
        bus_busy_i = 1'b1;
        drain_count(n);
        chk(n == 5, "R6", "bytes held from odd start", n, 5);

        // R2 / R9: busy bus blocks fetch; pops on empty are ignored
        redirect_to(20'h0A0B0);
        pop_i = 1'b1;
        pop_first_i = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(fetch_req_o == 1'b0, "R2", "no fetch on busy bus", fetch_req_o, 0);
            chk(qstat_o == 2'b00, "R9", "empty pop status", qstat_o, 0);
            chk(pop_empty_o == 1'b1, "R9", "still empty", pop_empty_o, 1);
            tick();
        end
        pop_i = 1'b0;
        pop_first_i = 1'b0;
        bus_busy_i = 1'b0;
        do_pops(4);

        // R8: redirect while a request is outstanding
        lat = 6;
        redirect_to(20'h0C000);
        wait_req();
        repeat (2) tick();
        redirect_to(20'h0D011);
        for (int i = 0; i < 20 && fetch_req_o; i++) tick();
        wait_req();
        @(negedge clk);
        chk(fetch_addr_o == 20'h0D011, "R8", "fetch after stale response",
            fetch_addr_o, 20'h0D011);
        tick();
        do_pops(9);

        // mixed traffic with an intermittently busy bus
        lat = 2;
        redirect_to(20'h1F3FE);
        for (int i = 0; i < 120; i++) begin
            bus_busy_i = (i % 5 == 1);
            pop_i = (i % 2 == 0);
            pop_first_i = (i % 6 == 0);
            tick();
        end
        pop_i = 1'b0;
        bus_busy_i = 1'b0;
        repeat (5) tick();
        lat = 0;
        redirect_to(20'h00007);
        do_pops(12);

        summary();
    end

endmodule